// File: doc/BRIEF.md
# Two-Level Loop Sequencer for a Bit-Serial Multiplier

This block drives a bit-serial shift-and-add multiplier through a doubly nested loop. The inner loop runs for `N_LOOP` cycles; on each of them the multiplicand is shifted, the sum path is selected and the high product half is shifted. Each pass of the inner loop is followed by a single outer-loop cycle, which shifts the multiplier and both product halves and clears the carry storage. After `N_LOOP` outer cycles the sequencer goes back to rest and waits for the next `start` pulse.

The controller is a one-hot machine with three states: rest, inner and outer. Each datapath strobe is a direct decode of one or two state bits. The loop lengths are not held in the state. Two internal counters set them. Each counter counts from 0 to `N_LOOP-1`, has a clock enable and a synchronous clear with priority over the enable, and raises a terminal flag at its top value. The inner counter counts in the inner state and is cleared in the outer state. The outer counter counts in the outer state and is cleared at rest. All pins are plain control levels. There is no data stream and no handshake.

Top module: `nested_loop_ctrl`

## Requirements
- R1: While `arst_n` is low the block is at rest at once, without waiting for a clock: `idle`=1 and `outer_clr`=1, with every other strobe at 0.
- R2: At rest, `start`=1 at a rising edge moves the block into the inner state. With `start`=0 it stays at rest.
- R3: Every inner pass lasts exactly `N_LOOP` consecutive cycles and is followed by an outer cycle.
- R4: An outer cycle lasts one cycle. It is followed by another inner pass unless it is the `N_LOOP`-th outer cycle of the job, which returns the block to rest.
- R5: From leaving rest until returning to it, the block spends exactly `N_LOOP*(N_LOOP+1)` cycles away from rest, and `N_LOOP` of those cycles are outer cycles.
- R6: In the inner state `inner_en`, `shift_a`, `shift_hi` and `sel_sum` are 1 and all other outputs are 0.
- R7: In the outer state `outer_en`, `inner_clr`, `shift_b`, `shift_lo`, `shift_hi` and `acc_clr` are 1 and all other outputs are 0.
- R8: At rest `idle` and `outer_clr` are 1 and all other outputs are 0.
- R9: `start` has no effect while a job is running. A job's length and strobe pattern are the same whether `start` is held, toggled or low. If `start` is still 1 on the cycle of return to rest, the next job begins on the following edge.
- R10: With `N_LOOP`=1 a job is one inner cycle followed by one outer cycle, and then the block is at rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| arst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a job when sampled at rest |
| idle | output | 1 | Block is at rest |
| outer_en | output | 1 | Count enable of the outer-loop counter |
| inner_en | output | 1 | Count enable of the inner-loop counter |
| outer_clr | output | 1 | Synchronous clear of the outer-loop counter |
| inner_clr | output | 1 | Synchronous clear of the inner-loop counter |
| shift_a | output | 1 | Shift the multiplicand register |
| shift_b | output | 1 | Shift the multiplier register |
| shift_lo | output | 1 | Shift the low product register |
| shift_hi | output | 1 | Shift the high product register |
| acc_clr | output | 1 | Clear the adder carry flop |
| sel_sum | output | 1 | Select the adder sum into the high product register |

## Verification
Every output is a decode of the state register, so a wrong state appears on the strobe pattern in the same cycle. A corrupted loop counter does not show as a wrong strobe. It shows as an inner pass of the wrong length, or as too few or too many outer cycles. The bench therefore compares the full strobe vector on every cycle against the position inside the job, and also totals the length of each job. A counter fault becomes visible no later than the end of the pass it spoils.

// File: rtl/nlc_pkg.sv
package nlc_pkg;
  localparam int ST_W    = 3;
  localparam int S_IDLE  = 0;
  localparam int S_INNER = 1;
  localparam int S_OUTER = 2;

  typedef logic [ST_W-1:0] state_t;

  localparam state_t ST_RESET = state_t'(1) << S_IDLE;

  typedef struct packed {
    logic outer_en;
    logic inner_en;
    logic outer_clr;
    logic inner_clr;
    logic shift_a;
    logic shift_b;
    logic shift_lo;
    logic shift_hi;
    logic acc_clr;
    logic sel_sum;
  } strobe_t;
endpackage

// File: rtl/nlc_loop_counter.sv
module nlc_loop_counter #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic arst_n,
  input  logic clr,
  input  logic en,
  output logic tc
);
  localparam int W = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [W-1:0] LAST = W'(LEN - 1);

  logic [W-1:0] cnt;

  // clear has priority over enable; the counter wraps after its top value
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (en)      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign tc = (cnt == LAST);

  a_r3_clear_wins: assert property (@(posedge clk) disable iff (!arst_n)
    clr |=> (cnt == '0));
  a_r3_step: assert property (@(posedge clk) disable iff (!arst_n)
    (en && !clr && cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));
  a_r4_wrap: assert property (@(posedge clk) disable iff (!arst_n)
    (en && !clr && cnt == LAST) |=> (cnt == '0));
  a_r3_hold: assert property (@(posedge clk) disable iff (!arst_n)
    (!en && !clr) |=> $stable(cnt));
endmodule

// File: rtl/nlc_seq_fsm.sv
module nlc_seq_fsm
  import nlc_pkg::*;
(
  input  logic   clk,
  input  logic   arst_n,
  input  logic   start,
  input  logic   tc_inner,
  input  logic   tc_outer,
  output state_t state
);
  state_t nxt;

  always_comb begin
    nxt = '0;
    if (state[S_INNER]) begin
      if (tc_inner) nxt[S_OUTER] = 1'b1;
      else          nxt[S_INNER] = 1'b1;
    end else if (state[S_OUTER]) begin
      if (tc_outer) nxt[S_IDLE]  = 1'b1;
      else          nxt[S_INNER] = 1'b1;
    end else if (state[S_IDLE] && start) begin
      nxt[S_INNER] = 1'b1;
    end else begin
      nxt[S_IDLE] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) state <= ST_RESET;
    else         state <= nxt;
  end

  a_r1_onehot: assert property (@(posedge clk) disable iff (!arst_n)
    $countones(state) == 1);
  a_r2_go: assert property (@(posedge clk) disable iff (!arst_n)
    (state[S_IDLE] && start) |=> state[S_INNER]);
  a_r2_wait: assert property (@(posedge clk) disable iff (!arst_n)
    (state[S_IDLE] && !start) |=> state[S_IDLE]);
  a_r3_exit: assert property (@(posedge clk) disable iff (!arst_n)
    (state[S_INNER] && tc_inner) |=> state[S_OUTER]);
  a_r3_stay: assert property (@(posedge clk) disable iff (!arst_n)
    (state[S_INNER] && !tc_inner) |=> state[S_INNER]);
  a_r4_again: assert property (@(posedge clk) disable iff (!arst_n)
    (state[S_OUTER] && !tc_outer) |=> state[S_INNER]);
  a_r4_done: assert property (@(posedge clk) disable iff (!arst_n)
    (state[S_OUTER] && tc_outer) |=> state[S_IDLE]);
endmodule

// File: rtl/nlc_strobe_dec.sv
module nlc_strobe_dec
  import nlc_pkg::*;
(
  input  state_t  state,
  output strobe_t strb
);
  always_comb begin
    strb           = '0;
    strb.outer_en  = state[S_OUTER];
    strb.inner_en  = state[S_INNER];
    strb.outer_clr = state[S_IDLE];
    strb.inner_clr = state[S_OUTER];
    strb.shift_a   = state[S_INNER];
    strb.shift_b   = state[S_OUTER];
    strb.shift_lo  = state[S_OUTER];
    strb.shift_hi  = state[S_INNER] | state[S_OUTER];
    strb.acc_clr   = state[S_OUTER];
    strb.sel_sum   = state[S_INNER];
  end
endmodule

// File: rtl/nested_loop_ctrl.sv
module nested_loop_ctrl
  import nlc_pkg::*;
#(
  parameter int N_LOOP = 8
) (
  input  logic clk,
  input  logic arst_n,
  input  logic start,
  output logic idle,
  output logic outer_en,
  output logic inner_en,
  output logic outer_clr,
  output logic inner_clr,
  output logic shift_a,
  output logic shift_b,
  output logic shift_lo,
  output logic shift_hi,
  output logic acc_clr,
  output logic sel_sum
);
  state_t  state;
  strobe_t strb;
  logic    tc_inner, tc_outer;

  nlc_seq_fsm u_fsm (
    .clk(clk), .arst_n(arst_n), .start(start),
    .tc_inner(tc_inner), .tc_outer(tc_outer), .state(state)
  );

  nlc_strobe_dec u_dec (.state(state), .strb(strb));

  nlc_loop_counter #(.LEN(N_LOOP)) u_inner_cnt (
    .clk(clk), .arst_n(arst_n), .clr(strb.inner_clr), .en(strb.inner_en), .tc(tc_inner)
  );

  nlc_loop_counter #(.LEN(N_LOOP)) u_outer_cnt (
    .clk(clk), .arst_n(arst_n), .clr(strb.outer_clr), .en(strb.outer_en), .tc(tc_outer)
  );

  assign idle      = state[S_IDLE];
  assign outer_en  = strb.outer_en;
  assign inner_en  = strb.inner_en;
  assign outer_clr = strb.outer_clr;
  assign inner_clr = strb.inner_clr;
  assign shift_a   = strb.shift_a;
  assign shift_b   = strb.shift_b;
  assign shift_lo  = strb.shift_lo;
  assign shift_hi  = strb.shift_hi;
  assign acc_clr   = strb.acc_clr;
  assign sel_sum   = strb.sel_sum;

  // R6 R7 R8: exactly one of rest, inner or outer is signalled at the pins
  a_r6_one_phase: assert property (@(posedge clk) disable iff (!arst_n)
    $countones({idle, inner_en, outer_en}) == 1);
  // R4: an outer cycle never lasts two cycles
  a_r4_single_outer: assert property (@(posedge clk) disable iff (!arst_n)
    outer_en |=> !outer_en);
  // R5: a job always leaves rest through the inner state
  a_r5_leave_inner: assert property (@(posedge clk) disable iff (!arst_n)
    (idle && start) |=> (inner_en && !idle));
endmodule

// File: tb/nested_loop_ctrl_tb.sv
module nested_loop_ctrl_tb;
  localparam int N0 = 8;
  localparam int N1 = 1;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic start = 1'b0;
  always #2.5 clk = ~clk;

  logic [10:0] v0, v1;

  nested_loop_ctrl #(.N_LOOP(N0)) u_dut (
    .clk(clk), .arst_n(arst_n), .start(start), .idle(v0[10]),
    .outer_en(v0[9]), .inner_en(v0[8]), .outer_clr(v0[7]), .inner_clr(v0[6]),
    .shift_a(v0[5]), .shift_b(v0[4]), .shift_lo(v0[3]), .shift_hi(v0[2]),
    .acc_clr(v0[1]), .sel_sum(v0[0])
  );

  nested_loop_ctrl #(.N_LOOP(N1)) u_dut1 (
    .clk(clk), .arst_n(arst_n), .start(start), .idle(v1[10]),
    .outer_en(v1[9]), .inner_en(v1[8]), .outer_clr(v1[7]), .inner_clr(v1[6]),
    .shift_a(v1[5]), .shift_b(v1[4]), .shift_lo(v1[3]), .shift_hi(v1[2]),
    .acc_clr(v1[1]), .sel_sum(v1[0])
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // bench models: busy flag and cycle index within the job
  bit busy0 = 0, busy1 = 0;
  int k0 = 0, k1 = 0;
  int len0 = 0, outs0 = 0, len1 = 0, outs1 = 0;

  // 0 rest, 1 inner, 2 outer
  function automatic int phase_of(bit busy, int k, int n);
    if (!busy) return 0;
    return ((k % (n + 1)) < n) ? 1 : 2;
  endfunction

  // bit order: idle outer_en inner_en outer_clr inner_clr a b lo hi acc sel
  function automatic logic [10:0] exp_vec(int ph);
    case (ph)
      0:       return 11'b100_1000_0000;
      1:       return 11'b001_0010_0101;
      default: return 11'b010_0101_1110;
    endcase
  endfunction

  function automatic string tag_of(int ph);
    case (ph)
      0:       return "R2 R8";
      1:       return "R3 R6";
      default: return "R4 R7";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // called at a negedge: compare pins and track job lengths
  task automatic observe();
    int ph0, ph1;
    ph0 = phase_of(busy0, k0, N0);
    ph1 = phase_of(busy1, k1, N1);
    chk({tag_of(ph0), " n=8"}, 32'(v0), 32'(exp_vec(ph0)));
    chk({"R10 ", tag_of(ph1)}, 32'(v1), 32'(exp_vec(ph1)));
    if (!v0[10]) begin len0++; if (v0[9]) outs0++; end
    else if (len0 > 0) begin
      chk("R5 R9 job length", 32'(len0), 32'(N0 * (N0 + 1)));
      chk("R5 outer count", 32'(outs0), 32'(N0));
      len0 = 0; outs0 = 0;
    end
    if (!v1[10]) begin len1++; if (v1[9]) outs1++; end
    else if (len1 > 0) begin
      chk("R10 job length", 32'(len1), 32'(2));
      chk("R10 outer count", 32'(outs1), 32'(1));
      len1 = 0; outs1 = 0;
    end
  endtask

  task automatic step(bit st);
    observe();
    start = st;
    @(posedge clk);
    if (!busy0 && st) begin busy0 = 1; k0 = 0; end
    else if (busy0) begin k0++; if (k0 == N0 * (N0 + 1)) busy0 = 0; end
    if (!busy1 && st) begin busy1 = 1; k1 = 0; end
    else if (busy1) begin k1++; if (k1 == N1 * (N1 + 1)) busy1 = 0; end
    @(negedge clk);
  endtask

  task automatic do_reset();
    arst_n = 1'b0;
    #1;
    // R1: rest shows without a clock edge
    chk("R1 async rest n=8", 32'(v0), 32'(exp_vec(0)));
    chk("R1 async rest n=1", 32'(v1), 32'(exp_vec(0)));
    busy0 = 0; busy1 = 0; k0 = 0; k1 = 0;
    len0 = 0; outs0 = 0; len1 = 0; outs1 = 0;
    @(negedge clk);
    arst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_0042);
    @(negedge clk);
    do_reset();
    // R2: rest holds while start is low
    for (int i = 0; i < 4; i++) step(1'b0);
    // directed single job with start low after launch (R3 R4 R5)
    step(1'b1);
    for (int i = 0; i < 80; i++) step(1'b0);
    // random start activity, including pulses during a job (R9)
    for (int i = 0; i < 1500; i++) begin
      if (i == 700) do_reset();
      step(($urandom % 4) == 0);
    end
    // start held high: back-to-back jobs (R9)
    for (int i = 0; i < 250; i++) step(1'b1);
    // drop start and let the last job drain
    for (int i = 0; i < 90; i++) step(1'b0);
    // reset in the middle of a job (R1)
    step(1'b1);
    for (int i = 0; i < 20; i++) step(1'b0);
    do_reset();
    for (int i = 0; i < 3; i++) step(1'b0);
    finish_run();
  end
endmodule